// File: doc/BRIEF.md
# Processor Interrupt Presentation Unit

This unit presents interrupts to one processor. It holds five pieces of state: the priority the processor is running at, an inter-processor request priority, the number of the source waiting to be taken, the priority of that waiting source, and a flag that records a delivery attempt that was turned away. Lower priority numbers win. Source value 0 means that no source is waiting. Source value 2 is reserved for the inter-processor request.

Commands arrive one per clock through a valid/ready handshake. There are five: offer a source, take the waiting source, change the running priority, change the inter-processor priority, and signal end of service. The unit drives a level interrupt line to the processor. It also drives single-cycle pulses for an accept response, for a displaced source that must be offered again, for a request that turned-away sources be retried, and for an end-of-service notice to the source side.

Top module: `irq_present_unit`

## Requirements
- R1: Offer (op 0, priority in data[31:24], source in data[23:0]) succeeds only when the running, inter-processor and waiting priorities are all strictly greater than the offered priority. On success the waiting slot takes the new source and priority, and the previous occupant is displaced.
- R2: A failed offer leaves the waiting slot untouched and sets the retry flag.
- R3: ext_irq is high exactly when the waiting source is nonzero and its priority is below the running priority.
- R4: Take (op 1) pulses rsp_valid on the next cycle, with the running priority in rsp_word[31:24] and the waiting source in rsp_word[23:0], both as they stood before the command. If a source was waiting, the running priority becomes the waiting priority, the waiting priority becomes 0xFF and the source becomes 0.
- R5: Set inter-processor priority (op 3, value in data[7:0]) stores the value. If the value is below the running priority and not above the waiting priority, the waiting source is displaced and replaced by code 2 at that value.
- R6: When op 3 raises the inter-processor priority value above its old value, the retry flag is emitted on resend_req and then cleared.
- R7: Set running priority (op 2, value in data[7:0]) equal to the current value changes nothing.
- R8: A larger value in op 2 lowers the priority. The running priority takes the value. If the inter-processor priority is below the new value and not above the waiting priority, code 2 becomes waiting at the inter-processor priority. The retry flag is emitted on resend_req and cleared.
- R9: A smaller value in op 2 raises the priority. If the new value is not above the waiting priority, the waiting source is displaced, the source becomes 0 and the waiting priority becomes 0xFF.
- R10: End of service (op 4) applies the R8 lowering step with data[31:24]. It pulses eoi_valid with data[23:0] on eoi_src unless that field equals 2.
- R11: A displaced value of 0 or 2 is never shown on rej_valid/rej_src.
- R12: After reset the running priority is 0x00, the inter-processor and waiting priorities are 0xFF, the source and retry flag are 0, and no output is asserted.
- R13: Op codes 5 to 7 have no effect on state or outputs.
- R14: cmd_ready is high from the first cycle after reset and stays high, so one command is taken per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken when high with cmd_valid |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 32 | Command argument |
| ext_irq | output | 1 | Interrupt line to the processor |
| rsp_valid | output | 1 | Take response pulse |
| rsp_word | output | 32 | Take response: priority and source |
| rej_valid | output | 1 | Displaced source pulse |
| rej_src | output | 24 | Displaced source number |
| resend_req | output | 1 | Retry request pulse |
| eoi_valid | output | 1 | End-of-service notice pulse |
| eoi_src | output | 24 | Source whose service ended |

## Verification
The assertions assume that commands change only at clock edges and that cmd_valid is low while reset is held. Under those conditions every output pulse can be traced to the command accepted in the cycle before. The stimulus drives inputs only on falling edges and keeps cmd_valid low through reset. It draws priorities mostly from a narrow band plus 0xFF, and sources from a small set that includes 0 and 2, so that equal-priority ties, displacement of the reserved codes and retry release happen often.

// File: rtl/irq_present_unit.sv
module irq_present_unit #(
  parameter int SRC_W    = 24,
  parameter int PRIO_W   = 8,
  parameter int IPI_CODE = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [2:0]                cmd_op,
  input  logic [PRIO_W+SRC_W-1:0]   cmd_data,
  output logic                      ext_irq,
  output logic                      rsp_valid,
  output logic [PRIO_W+SRC_W-1:0]   rsp_word,
  output logic                      rej_valid,
  output logic [SRC_W-1:0]          rej_src,
  output logic                      resend_req,
  output logic                      eoi_valid,
  output logic [SRC_W-1:0]          eoi_src
);
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI   = SRC_W'(IPI_CODE);
  localparam logic [2:0] OP_OFFER = 3'd0, OP_TAKE = 3'd1, OP_RUN = 3'd2,
                         OP_IPI = 3'd3, OP_DONE = 3'd4;

  logic [PRIO_W-1:0] run_q, ipi_q, wait_q;
  logic [SRC_W-1:0]  src_q;
  logic              retry_q;

  logic [PRIO_W-1:0] run_d, ipi_d, wait_d;
  logic [SRC_W-1:0]  src_d;
  logic              retry_d;
  logic              disp_hit, resend_d, take_d, done_d, lower;
  logic [SRC_W-1:0]  disp_val;

  wire              fire     = cmd_valid & cmd_ready;
  wire [PRIO_W-1:0] arg_lo   = cmd_data[PRIO_W-1:0];
  wire [PRIO_W-1:0] arg_hi   = cmd_data[WORD_W-1:SRC_W];
  wire [SRC_W-1:0]  arg_src  = cmd_data[SRC_W-1:0];
  wire [PRIO_W-1:0] low_val  = (cmd_op == OP_DONE) ? arg_hi : arg_lo;

  assign ext_irq = (src_q != '0) && (wait_q < run_q);

  always_comb begin
    run_d    = run_q;
    ipi_d    = ipi_q;
    wait_d   = wait_q;
    src_d    = src_q;
    retry_d  = retry_q;
    disp_hit = 1'b0;
    disp_val = '0;
    resend_d = 1'b0;
    take_d   = 1'b0;
    done_d   = 1'b0;
    lower    = 1'b0;
    if (fire) begin
      case (cmd_op)
        OP_OFFER: begin
          if (run_q > arg_hi && ipi_q > arg_hi && wait_q > arg_hi) begin
            disp_hit = 1'b1;
            disp_val = src_q;
            src_d    = arg_src;
            wait_d   = arg_hi;
          end else begin
            retry_d = 1'b1;
          end
        end
        OP_TAKE: begin
          take_d = 1'b1;
          if (src_q != '0) begin
            run_d  = wait_q;
            wait_d = LEAST;
            src_d  = '0;
          end
        end
        OP_IPI: begin
          ipi_d = arg_lo;
          if (arg_lo < run_q && arg_lo <= wait_q) begin
            disp_hit = 1'b1;
            disp_val = src_q;
            wait_d   = arg_lo;
            src_d    = IPI;
          end
          if (arg_lo > ipi_q) begin
            resend_d = retry_q;
            retry_d  = 1'b0;
          end
        end
        OP_RUN: begin
          if (arg_lo > run_q) begin
            lower = 1'b1;
          end else if (arg_lo < run_q) begin
            run_d = arg_lo;
            if (arg_lo <= wait_q) begin
              disp_hit = 1'b1;
              disp_val = src_q;
              src_d    = '0;
              wait_d   = LEAST;
            end
          end
        end
        OP_DONE: begin
          lower  = 1'b1;
          done_d = (arg_src != IPI);
        end
        default: ;
      endcase
      if (lower) begin
        run_d = low_val;
        if (ipi_q < low_val && ipi_q <= wait_q) begin
          wait_d = ipi_q;
          src_d  = IPI;
        end
        resend_d = retry_q;
        retry_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_ready  <= 1'b0;
      run_q      <= '0;
      ipi_q      <= LEAST;
      wait_q     <= LEAST;
      src_q      <= '0;
      retry_q    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_word   <= '0;
      rej_valid  <= 1'b0;
      rej_src    <= '0;
      resend_req <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_src    <= '0;
    end else begin
      cmd_ready  <= 1'b1;
      run_q      <= run_d;
      ipi_q      <= ipi_d;
      wait_q     <= wait_d;
      src_q      <= src_d;
      retry_q    <= retry_d;
      rsp_valid  <= take_d;
      rsp_word   <= take_d ? {run_q, src_q} : '0;
      rej_valid  <= disp_hit && disp_val != '0 && disp_val != IPI;
      rej_src    <= (disp_hit && disp_val != '0 && disp_val != IPI) ? disp_val : '0;
      resend_req <= resend_d;
      eoi_valid  <= done_d;
      eoi_src    <= done_d ? arg_src : '0;
    end
  end
endmodule

// File: rtl/irq_present_unit_chk.sv
module irq_present_unit_chk #(
  parameter int SRC_W    = 24,
  parameter int PRIO_W   = 8,
  parameter int IPI_CODE = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic                    cmd_ready,
  input logic [2:0]              cmd_op,
  input logic                    rsp_valid,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    resend_req,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src
);
  wire fire = cmd_valid && cmd_ready;

  p_ready_holds_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> cmd_ready);

  p_disp_filter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0 && rej_src != SRC_W'(IPI_CODE)));

  p_done_skip_ipi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> eoi_src != SRC_W'(IPI_CODE));

  p_take_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 3'd1) |=> rsp_valid);

  p_resp_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(fire && cmd_op == 3'd1));

  p_resend_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> $past(fire && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4)));

  p_unused_op_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op > 3'd4) |=> !(rsp_valid || rej_valid || resend_req || eoi_valid));
endmodule

bind irq_present_unit irq_present_unit_chk #(
  .SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_CODE(IPI_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rej_valid(rej_valid),
  .rej_src(rej_src), .resend_req(resend_req), .eoi_valid(eoi_valid),
  .eoi_src(eoi_src)
);

// File: tb/irq_present_unit_tb_top.sv
module irq_present_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        ext_irq, rsp_valid, rej_valid, resend_req, eoi_valid;
  logic [31:0] rsp_word;
  logic [23:0] rej_src, eoi_src;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_present_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .ext_irq(ext_irq),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rej_valid(rej_valid),
    .rej_src(rej_src), .resend_req(resend_req), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src)
  );

  logic [7:0]  m_run, m_ipi, m_wait;
  logic [23:0] m_src;
  logic        m_retry;
  logic        e_rsp_v, e_rej_v, e_res, e_eoi_v;
  logic [31:0] e_rsp;
  logic [23:0] e_rej, e_eoi;
  string       t_main, t_rej, t_res;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_run = 8'h00; m_ipi = 8'hFF; m_wait = 8'hFF; m_src = '0; m_retry = 1'b0;
  endtask

  task automatic displace(input logic [23:0] v);
    if (v != 24'd0 && v != 24'd2) begin e_rej_v = 1'b1; e_rej = v; end
    else t_rej = "R11";
  endtask

  task automatic lower_step(input logic [7:0] v);
    m_run = v;
    if (m_ipi < v && m_ipi <= m_wait) begin m_wait = m_ipi; m_src = 24'd2; end
    e_res = m_retry;
    m_retry = 1'b0;
  endtask

  task automatic model_step(input logic [2:0] op, input logic [31:0] d);
    e_rsp_v = 0; e_rsp = 0; e_rej_v = 0; e_rej = 0; e_res = 0; e_eoi_v = 0; e_eoi = 0;
    t_rej = "R11"; t_res = "R13";
    case (op)
      3'd0: begin
        if (m_run > d[31:24] && m_ipi > d[31:24] && m_wait > d[31:24]) begin
          t_main = "R1"; t_rej = "R1";
          displace(m_src);
          m_src = d[23:0]; m_wait = d[31:24];
        end else begin
          t_main = "R2"; m_retry = 1'b1;
        end
      end
      3'd1: begin
        t_main = "R4";
        e_rsp_v = 1; e_rsp = {m_run, m_src};
        if (m_src != 0) begin m_run = m_wait; m_wait = 8'hFF; m_src = 0; end
      end
      3'd2: begin
        if (d[7:0] == m_run) t_main = "R7";
        else if (d[7:0] > m_run) begin t_main = "R8"; t_res = "R8"; lower_step(d[7:0]); end
        else begin
          t_main = "R9"; t_rej = "R9";
          m_run = d[7:0];
          if (d[7:0] <= m_wait) begin displace(m_src); m_src = 0; m_wait = 8'hFF; end
        end
      end
      3'd3: begin
        t_main = "R5"; t_rej = "R5"; t_res = "R6";
        if (d[7:0] < m_run && d[7:0] <= m_wait) begin
          displace(m_src); m_wait = d[7:0]; m_src = 24'd2;
        end
        if (d[7:0] > m_ipi) begin e_res = m_retry; m_retry = 1'b0; end
        m_ipi = d[7:0];
      end
      3'd4: begin
        t_main = "R10"; t_res = "R10";
        lower_step(d[31:24]);
        if (d[23:0] != 24'd2) begin e_eoi_v = 1; e_eoi = d[23:0]; end
      end
      default: t_main = "R13";
    endcase
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] d);
    model_step(op, d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R14", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R3", "ext_irq", {31'd0, ext_irq}, {31'd0, (m_src != 0) && (m_wait < m_run)});
    chk(t_main, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_rsp_v});
    if (e_rsp_v) chk(t_main, "rsp_word", rsp_word, e_rsp);
    chk(t_rej, "rej_valid", {31'd0, rej_valid}, {31'd0, e_rej_v});
    if (e_rej_v) chk(t_rej, "rej_src", {8'd0, rej_src}, {8'd0, e_rej});
    chk(t_res, "resend_req", {31'd0, resend_req}, {31'd0, e_res});
    chk("R10", "eoi_valid", {31'd0, eoi_valid}, {31'd0, e_eoi_v});
    if (e_eoi_v) chk("R10", "eoi_src", {8'd0, eoi_src}, {8'd0, e_eoi});
  endtask

  function automatic logic [7:0] pick_prio();
    int unsigned r = $urandom % 12;
    if (r < 9) return 8'(r);
    if (r < 11) return 8'hFF;
    return 8'($urandom);
  endfunction

  function automatic logic [23:0] pick_src();
    int unsigned r = $urandom % 14;
    if (r < 12) return 24'(r);
    return 24'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd715);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state visible at the ports
    chk("R12", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
    chk("R12", "ext_irq", {31'd0, ext_irq}, 32'd0);
    chk("R12", "pulses", {28'd0, rsp_valid, rej_valid, resend_req, eoi_valid}, 32'd0);
    issue(3'd1, 32'd0);                       // R12 take shows run 00, source 0
    chk("R12", "rsp_word", rsp_word, 32'h0000_0000);
    issue(3'd2, 32'h0000_00FF);               // R8 lower, no IPI since ipi is 0xFF
    issue(3'd0, {8'd5, 24'd7});               // R1
    issue(3'd0, {8'd3, 24'd9});               // R1 displaces 7
    issue(3'd0, {8'd4, 24'd11});              // R2 refused
    issue(3'd3, 32'd1);                       // R5 displaces 9
    issue(3'd3, 32'd6);                       // R6 releases retry
    issue(3'd1, 32'd0);                       // R4
    issue(3'd2, 32'd1);                       // R7 equal
    issue(3'd4, {8'hFF, 24'd2});              // R10 no notice for code 2
    issue(3'd1, 32'd0);
    issue(3'd0, {8'd2, 24'd5});
    issue(3'd2, 32'd0);                       // R9 raise displaces 5
    issue(3'd6, 32'hFFFF_FFFF);               // R13
    issue(3'd4, {8'h80, 24'd33});             // R10
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      case (op)
        3'd0: issue(op, {pick_prio(), pick_src()});
        3'd4: issue(op, {pick_prio(), pick_src()});
        default: issue(op, {24'($urandom), pick_prio()});
      endcase
      if (i == 1500) begin
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R12", "ext_irq after reset", {31'd0, ext_irq}, 32'd0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule